// File: doc/BRIEF.md
# Position Decoder Status Register

This block holds the 16-bit status word of a position decoder that handles quadrature and Hall sensor signals. The decoder core reports single-cycle events to it: decode errors, writes to the shadow buffers of the compare, filter and prescaler registers, and update conditions. It also supplies the current rotation direction, the run/stop state and the operating mode. The block keeps the error flags until software clears them. It keeps the buffer-valid flags until software clears them or an update event consumes the buffers.

Software reaches the word one byte at a time through a small register port. A write of 1 to a flag clears that flag. Writes go through a fixed two-cycle synchronizer. While the synchronizer is busy a busy flag is high, and software must wait for it to drop before reading back the result. Reads are combinational. Each flag reads as zero when the selected operating mode does not use it.

Top module: `posdec_status`

## Requirements
- R1: While reset is held, and directly after it, the stored word is 0x0040: only the stop bit (bit 6) is 1. In quadrature mode byte 0 reads 0x40 and byte 1 reads 0x00, and `sync_busy` is 0.
- R2: The error flags are sticky. They are quadrature error at bit 0, index error at bit 1, missing pulse at bit 2, window error at bit 4 and Hall code error at bit 5. Each sets on the clock edge after its event input is high and stays set until a write of 1 to its bit takes effect. A write of 0 leaves it set.
- R3: The buffer-valid flags are prescaler at bit 8, filter at bit 9, compare 0 at bit 12 and compare 1 at bit 13. Each sets on the edge after its buffer-write input is high. It clears on a write of 1 to its bit, or on the edge after `ev_update` is high.
- R4: The mode input is 00 for counter, 01 for quadrature, 10 for Hall and 11 reserved. Bits 0, 1 and 2 read 0 unless the mode is 01. Bits 4 and 5 read 0 unless the mode is 10. Bits 6, 7 and 9 read 0 in modes 00 and 11. The stored flags are not altered by this masking.
- R5: Bit 7 reads `dir_in` and bit 6 reads `stop_in` as sampled at the previous clock edge.
- R6: A write accepted at a clock edge raises `sync_busy` for exactly two cycles. The clear takes effect at the edge where `sync_busy` falls, so the read-back is valid as soon as busy reads 0.
- R7: A write presented while `sync_busy` is high is ignored and clears nothing.
- R8: If a set event and a software clear hit the same bit at the same edge, the bit ends up set.
- R9: A buffer-write event at the same edge as an update event leaves that buffer-valid bit set.
- R10: Bits 3, 10, 11, 14 and 15 always read 0, and writes to them have no effect.
- R11: `bus_addr` 0 selects bits 7:0 and `bus_addr` 1 selects bits 15:8, for both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Byte select: 0 for bits 7:0, 1 for bits 15:8 |
| bus_wr | input | 1 | Write strobe, write-1-to-clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Mode-masked read data of the selected byte |
| sync_busy | output | 1 | Write synchronizer busy |
| ev_qerr | input | 1 | Invalid quadrature transition event |
| ev_idxerr | input | 1 | Index error event |
| ev_mperr | input | 1 | Missing pulse event |
| ev_winerr | input | 1 | Counter outside window event |
| ev_herr | input | 1 | Invalid Hall code event |
| ev_cc_wr | input | 2 | Compare buffer write events, channel 1:0 |
| ev_filt_wr | input | 1 | Filter buffer write event |
| ev_presc_wr | input | 1 | Prescaler buffer write event |
| ev_update | input | 1 | Update condition, consumes buffers |
| dir_in | input | 1 | Direction, 1 is counter-clockwise |
| stop_in | input | 1 | Decoding stopped |
| mode | input | 2 | Operating mode |

## Verification
A flag reacts to an event input on the first clock edge after that input is high. The bench therefore drives each pulse at a falling edge and reads at the next falling edge. A clear is due at the third rising edge after the write strobe is driven: the first edge accepts the write and the third applies it. The bench checks `sync_busy` high after the first and second edges and low after the third, and reads the result only then. The set-wins case is timed so that its event lands exactly on that third edge. Reads are combinational, so the bench sweeps all four modes over one stored word without waiting any clock cycles in between.

// File: rtl/posdec_status_pkg.sv
package posdec_status_pkg;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_COUNT = 2'b00,
    MODE_QUAD  = 2'b01,
    MODE_HALL  = 2'b10,
    MODE_RSVD  = 2'b11
  } pd_mode_e;

  // bit positions that the read masking depends on
  localparam int B_QERR = 0, B_IDX = 1, B_MP = 2, B_WIN = 4, B_HERR = 5;
  localparam int B_STOP = 6, B_DIR = 7, B_FILT = 9;

  localparam logic [REG_W-1:0] IMPL_MASK   = 16'h33F7;
  localparam logic [REG_W-1:0] STICKY_MASK = 16'h0037;
  localparam logic [REG_W-1:0] BUFV_MASK   = 16'h3300;
  localparam logic [REG_W-1:0] FOLLOW_MASK = 16'h00C0;
  localparam logic [REG_W-1:0] RESET_WORD  = 16'h0040;

  function automatic logic [REG_W-1:0] lane_place(input logic hi, input logic [BYTE_W-1:0] d);
    return hi ? {d, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, d};
  endfunction

  function automatic logic [REG_W-1:0] read_view(input logic [REG_W-1:0] q, input logic [1:0] m);
    logic [REG_W-1:0] v;
    logic quad, hall;
    quad = (pd_mode_e'(m) == MODE_QUAD);
    hall = (pd_mode_e'(m) == MODE_HALL);
    v = q & IMPL_MASK;
    if (!quad) begin
      v[B_QERR] = 1'b0; v[B_IDX] = 1'b0; v[B_MP] = 1'b0;
    end
    if (!hall) begin
      v[B_WIN] = 1'b0; v[B_HERR] = 1'b0;
    end
    if (!(quad || hall)) begin
      v[B_STOP] = 1'b0; v[B_DIR] = 1'b0; v[B_FILT] = 1'b0;
    end
    return v;
  endfunction
endpackage

// File: rtl/posdec_wsync.sv
module posdec_wsync #(
  parameter int DATA_W = 8,
  parameter int REG_W  = 16,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic [REG_W-1:0]  clr_vec
);
  import posdec_status_pkg::*;
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [CNT_W-1:0]  cnt;
  logic              pend_addr;
  logic [DATA_W-1:0] pend_data;
  logic              accept;
  logic              apply;

  assign busy   = (cnt != '0);
  assign accept = wr && !busy;
  assign apply  = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pend_addr <= 1'b0;
      pend_data <= '0;
    end else if (accept) begin
      cnt       <= CNT_W'(STAGES);
      pend_addr <= addr;
      pend_data <= wdata;
    end else if (busy) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign clr_vec = apply ? lane_place(pend_addr, pend_data) : '0;

  assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_busy_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> !busy);
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && busy) |=> $stable(pend_data) && $stable(pend_addr));
endmodule

// File: rtl/posdec_flag_bank.sv
module posdec_flag_bank #(
  parameter int                W      = 16,
  parameter logic [W-1:0]      IMPL   = '0,
  parameter logic [W-1:0]      STICKY = '0,
  parameter logic [W-1:0]      BUFV   = '0,
  parameter logic [W-1:0]      FOLLOW = '0,
  parameter logic [W-1:0]      RSTV   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         upd,
  output logic [W-1:0] q
);
  logic unused_spare;
  assign unused_spare = ^((set_vec | clr_vec) & ~IMPL);

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_none
      assign q[i] = 1'b0;
    end else if (FOLLOW[i]) begin : g_follow
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= RSTV[i];
        else        q[i] <= set_vec[i];
      end
    end else begin : g_flag
      logic drop;
      assign drop = clr_vec[i] || (BUFV[i] && upd);
      always_ff @(posedge clk) begin
        if (!rst_n) q[i] <= RSTV[i];
        else        q[i] <= set_vec[i] || (q[i] && !drop);
      end
      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[i] |=> q[i]);
      if (BUFV[i]) begin : g_upd
        assert_upd_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
          (upd && !set_vec[i]) |=> !q[i]);
      end
      if (STICKY[i]) begin : g_hold
        assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
          (q[i] && !clr_vec[i]) |=> q[i]);
      end
    end
  end
endmodule

// File: rtl/posdec_rd_view.sv
module posdec_rd_view #(
  parameter int REG_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic [REG_W-1:0]  q,
  input  logic [1:0]        mode,
  input  logic              addr,
  output logic [BYTE_W-1:0] rdata
);
  import posdec_status_pkg::*;
  logic [REG_W-1:0] view;
  assign view  = read_view(q, mode);
  assign rdata = addr ? view[REG_W-1:BYTE_W] : view[BYTE_W-1:0];
endmodule

// File: rtl/posdec_status.sv
module posdec_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sync_busy,
  input  logic       ev_qerr,
  input  logic       ev_idxerr,
  input  logic       ev_mperr,
  input  logic       ev_winerr,
  input  logic       ev_herr,
  input  logic [1:0] ev_cc_wr,
  input  logic       ev_filt_wr,
  input  logic       ev_presc_wr,
  input  logic       ev_update,
  input  logic       dir_in,
  input  logic       stop_in,
  input  logic [1:0] mode
);
  import posdec_status_pkg::*;

  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] clr_vec;
  logic [REG_W-1:0] flags;

  always_comb begin
    set_vec         = '0;
    set_vec[B_QERR] = ev_qerr;
    set_vec[B_IDX]  = ev_idxerr;
    set_vec[B_MP]   = ev_mperr;
    set_vec[B_WIN]  = ev_winerr;
    set_vec[B_HERR] = ev_herr;
    set_vec[B_STOP] = stop_in;
    set_vec[B_DIR]  = dir_in;
    set_vec[8]      = ev_presc_wr;
    set_vec[B_FILT] = ev_filt_wr;
    set_vec[13:12]  = ev_cc_wr;
  end

  posdec_wsync #(.DATA_W(BYTE_W), .REG_W(REG_W), .STAGES(2)) u_wsync (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(sync_busy), .clr_vec(clr_vec));

  posdec_flag_bank #(.W(REG_W), .IMPL(IMPL_MASK), .STICKY(STICKY_MASK),
    .BUFV(BUFV_MASK), .FOLLOW(FOLLOW_MASK), .RSTV(RESET_WORD)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .upd(ev_update), .q(flags));

  posdec_rd_view #(.REG_W(REG_W), .BYTE_W(BYTE_W)) u_view (
    .q(flags), .mode(mode), .addr(bus_addr), .rdata(bus_rdata));

  assert_dir_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags[B_DIR] == $past(dir_in)) && (flags[B_STOP] == $past(stop_in)));
  assert_unimpl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr ? (bus_rdata[2] == 1'b0 && bus_rdata[3] == 1'b0 && bus_rdata[7:6] == 2'b00)
             : (bus_rdata[3] == 1'b0));
  assert_mode_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01 && !bus_addr) |-> (bus_rdata[2:0] == 3'b000));
endmodule

// File: tb/sim_posdec_status.sv
module sim_posdec_status;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_addr = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic sync_busy;
  logic ev_qerr = 0, ev_idxerr = 0, ev_mperr = 0, ev_winerr = 0, ev_herr = 0;
  logic [1:0] ev_cc_wr = '0;
  logic ev_filt_wr = 0, ev_presc_wr = 0, ev_update = 0, dir_in = 0, stop_in = 1;
  logic [1:0] mode = 2'b01;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  posdec_status u0 (.*);

  function automatic logic [15:0] mode_mask(input int m);
    case (m)
      1:       return 16'h33C7;
      2:       return 16'h33F0;
      default: return 16'h3100;
    endcase
  endfunction

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic wr_byte(input logic a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic wr_done(input logic a, input logic [7:0] d);
    wr_byte(a, d); step(); step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi;
    repeat (3) step();
    rd(0, lo); rd(1, hi);
    chk("R1 reset word", {hi, lo}, 16'h0040);
    chk("R1 busy", {15'b0, sync_busy}, 16'h0000);
    rst_n = 1'b1;
    rd(0, lo);
    chk("R1 after release", {8'h0, lo}, 16'h0040);

    dir_in = 1; stop_in = 0; step();
    rd(0, lo); chk("R5 dir/stop follow", {8'h0, lo}, 16'h0080);
    mode = 2'b00; rd(0, lo); chk("R4 dir masked in counter", {8'h0, lo}, 16'h0000);
    mode = 2'b01; dir_in = 0;

    ev_qerr = 1; ev_idxerr = 1; ev_mperr = 1; ev_winerr = 1; ev_herr = 1;
    ev_cc_wr = 2'b11; ev_filt_wr = 1; ev_presc_wr = 1;
    step();
    ev_qerr = 0; ev_idxerr = 0; ev_mperr = 0; ev_winerr = 0; ev_herr = 0;
    ev_cc_wr = 2'b00; ev_filt_wr = 0; ev_presc_wr = 0;
    step();
    for (int m = 0; m < 4; m++) begin
      mode = 2'(m);
      rd(0, lo); rd(1, hi);
      chk($sformatf("R4 R2 R3 sweep mode %0d", m), {hi, lo}, 16'h3337 & mode_mask(m));
    end
    mode = 2'b01;

    wr_done(0, 8'h00);
    rd(0, lo); chk("R2 write zero keeps", {8'h0, lo}, 16'h0007);

    wr_byte(0, 8'h01);
    chk("R6 busy cycle 1", {15'b0, sync_busy}, 16'h0001);
    bus_wdata = 8'h02; bus_wr = 1; step(); bus_wr = 0;
    chk("R6 busy cycle 2", {15'b0, sync_busy}, 16'h0001);
    rd(0, lo); chk("R6 not yet applied", {8'h0, lo}, 16'h0007);
    step();
    chk("R6 busy low", {15'b0, sync_busy}, 16'h0000);
    rd(0, lo); chk("R7 busy write ignored, R6 clear applied", {8'h0, lo}, 16'h0006);

    wr_done(1, 8'h10);
    rd(1, hi); chk("R11 high lane clear", {8'h0, hi}, 16'h0023);
    wr_done(1, 8'hCC);
    rd(1, hi); chk("R10 high unimpl", {8'h0, hi}, 16'h0023);
    wr_done(0, 8'h08);
    rd(0, lo); chk("R10 bit3 write", {8'h0, lo}, 16'h0006);

    ev_update = 1; step(); ev_update = 0;
    rd(1, hi); chk("R3 update clears", {8'h0, hi}, 16'h0000);
    ev_update = 1; ev_cc_wr = 2'b01; step(); ev_update = 0; ev_cc_wr = 2'b00;
    rd(1, hi); chk("R9 set beats update", {8'h0, hi}, 16'h0010);
    wr_done(1, 8'h10);
    rd(1, hi); chk("R3 write clears", {8'h0, hi}, 16'h0000);

    ev_qerr = 1; step(); ev_qerr = 0;
    rd(0, lo); chk("R2 qerr set", {8'h0, lo}, 16'h0007);
    wr_byte(0, 8'h01); step();
    ev_qerr = 1; step(); ev_qerr = 0;
    rd(0, lo); chk("R8 set beats clear", {8'h0, lo}, 16'h0007);

    mode = 2'b10; ev_herr = 1; step(); ev_herr = 0;
    rd(0, lo); chk("R2 hall flags", {8'h0, lo}, 16'h0030);
    wr_done(0, 8'h20);
    rd(0, lo); chk("R2 herr cleared", {8'h0, lo}, 16'h0010);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule